// File: doc/BRIEF.md
# Parallel Visited-Bit Claim Arbiter

This block decides which lanes of a wide vector own the nodes they name. In one step of a level-by-level graph expansion, every lane presents a node index in the same cycle. The block keeps one visited bit per node. For all active lanes together it reads and sets that bit as one indivisible action. It then returns a winner mask in which at most one lane is set for any node.

A lane wins only if its node was unvisited before the request, and only the winning lanes go on to enqueue their node. When several active lanes name the same fresh node, the lowest-numbered of them is the winner. The other lanes naming that node see the bit as already set.

Results appear one cycle after the request. A request sees every bit that the previous request set, even when the two are back to back. A clear command empties the whole bitmap.

Top module: `visit_claim_arb`

## Requirements
- R1: After reset, `rsp_valid_o`, `win_o` and `old_o` are all 0, and every visited bit is 0, so a first request to any nodes wins on every active lane whose node is named by no lower active lane.
- R2: `rsp_valid_o` is 1 exactly in the cycle after a cycle with `req_valid_i`=1 and `clr_i`=0. Otherwise it is 0.
- R3: An active lane whose node was unvisited and is named by no lower-numbered active lane reports `old_o`=0 and `win_o`=1. Afterwards that node's bit is 1.
- R4: An active lane whose node was already visited before the request reports `old_o`=1 and `win_o`=0.
- R5: When several active lanes in one request name the same unvisited node, the lowest-numbered of them wins. Each of the others reports `old_o`=1 and `win_o`=0. No two winners in one response share a node.
- R6: A lane with `lane_act_i[k]`=0 reports `win_o[k]`=0 and `old_o[k]`=0, and leaves the visited bit of its node unchanged.
- R7: Bits set by one request are seen by a request in the very next cycle.
- R8: `clr_i`=1 sets every visited bit to 0. A request in the same cycle is dropped: it gets no response and sets no bit.
- R9: In a cycle where `rsp_valid_o`=0, `win_o` and `old_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Clear the whole visited bitmap; takes priority over a request |
| req_valid_i | input | 1 | A request is present this cycle |
| lane_act_i | input | LANES | Active-lane mask, bit k for lane k |
| node_idx_i | input | LANES*IDX_W | Node index of lane k in bits [k*IDX_W +: IDX_W] |
| win_o | output | LANES | Winner mask of the previous cycle's request |
| old_o | output | LANES | Per-lane visited value seen before the set |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |

## Verification
The bench builds the block with its defaults: 8 lanes and 8-bit indices, which gives a bitmap of 256 nodes. With eight lanes, one request can hold a duplicate group of every size from two to eight, including a group whose lowest lane is inactive. The directed steps reach node 255, a clear issued alongside a request, and back-to-back reuse of a node. A pseudo-random phase then draws indices from a narrow window, so duplicates within one request and hits on nodes set earlier occur in most requests.

// File: rtl/visit_claim_arb.sv
module visit_claim_arb #(
  parameter int LANES = 8,
  parameter int IDX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_i,
  input  logic                   req_valid_i,
  input  logic [LANES-1:0]       lane_act_i,
  input  logic [LANES*IDX_W-1:0] node_idx_i,
  output logic [LANES-1:0]       win_o,
  output logic [LANES-1:0]       old_o,
  output logic                   rsp_valid_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] seen_q;
  logic [DEPTH-1:0] set_mask;
  logic [LANES-1:0] old_d;
  logic [LANES-1:0] win_q, old_q;
  logic             rsp_q;

  wire go = req_valid_i & ~clr_i;

  always_comb begin
    old_d    = '0;
    set_mask = '0;
    for (int k = 0; k < LANES; k++) begin
      if (lane_act_i[k]) begin
        old_d[k] = seen_q[node_idx_i[k*IDX_W +: IDX_W]];
        for (int j = 0; j < k; j++)
          if (lane_act_i[j] &&
              node_idx_i[j*IDX_W +: IDX_W] == node_idx_i[k*IDX_W +: IDX_W])
            old_d[k] = 1'b1;
        set_mask[node_idx_i[k*IDX_W +: IDX_W]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= '0;
      win_q  <= '0;
      old_q  <= '0;
      rsp_q  <= 1'b0;
    end else if (clr_i) begin
      seen_q <= '0;
      win_q  <= '0;
      old_q  <= '0;
      rsp_q  <= 1'b0;
    end else begin
      rsp_q <= go;
      if (go) begin
        seen_q <= seen_q | set_mask;
        win_q  <= lane_act_i & ~old_d;
        old_q  <= old_d;
      end else begin
        win_q  <= '0;
        old_q  <= '0;
      end
    end
  end

  assign win_o       = win_q;
  assign old_o       = old_q;
  assign rsp_valid_o = rsp_q;
endmodule

// File: rtl/visit_claim_arb_chk.sv
module visit_claim_arb_chk #(
  parameter int LANES = 8,
  parameter int IDX_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   clr_i,
  input logic                   req_valid_i,
  input logic [LANES-1:0]       lane_act_i,
  input logic [LANES*IDX_W-1:0] node_idx_i,
  input logic [LANES-1:0]       win_o,
  input logic [LANES-1:0]       old_o,
  input logic                   rsp_valid_o
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !clr_i) |=> rsp_valid_o); // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid_i && !clr_i) |=> !rsp_valid_o); // R2
  AST_CLR_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !rsp_valid_o); // R8
  AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid_o |-> (win_o == '0 && old_o == '0)); // R9
  AST_INACTIVE_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> (win_o & ~$past(lane_act_i)) == '0); // R6
  AST_INACTIVE_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> (old_o & ~$past(lane_act_i)) == '0); // R6

  for (genvar i = 0; i < LANES; i++) begin : g_a
    for (genvar j = i + 1; j < LANES; j++) begin : g_b
      AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && win_o[i] && win_o[j]) |->
          ($past(node_idx_i[i*IDX_W +: IDX_W]) != $past(node_idx_i[j*IDX_W +: IDX_W]))); // R5
      AST_LOW_LANE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && win_o[j] && $past(lane_act_i[i])) |->
          ($past(node_idx_i[i*IDX_W +: IDX_W]) != $past(node_idx_i[j*IDX_W +: IDX_W]))); // R5
    end
  end
endmodule

bind visit_claim_arb visit_claim_arb_chk #(.LANES(LANES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .req_valid_i(req_valid_i),
  .lane_act_i(lane_act_i), .node_idx_i(node_idx_i), .win_o(win_o),
  .old_o(old_o), .rsp_valid_o(rsp_valid_o)
);

// File: tb/test_visit_claim_arb.sv
`timescale 1ns/1ps
module test_visit_claim_arb;
  localparam int LANES = 8;
  localparam int IDX_W = 8;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_i = 1'b0;
  logic req_valid_i = 1'b0;
  logic [LANES-1:0] lane_act_i = '0;
  logic [LANES*IDX_W-1:0] node_idx_i = '0;
  logic [LANES-1:0] win_o, old_o;
  logic rsp_valid_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;
  bit vis [DEPTH];
  int lfsr = 32'h1d7a;

  always #2.5 clk = ~clk;

  visit_claim_arb #(.LANES(LANES), .IDX_W(IDX_W)) i_visit_claim_arb (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .req_valid_i(req_valid_i),
    .lane_act_i(lane_act_i), .node_idx_i(node_idx_i), .win_o(win_o),
    .old_o(old_o), .rsp_valid_o(rsp_valid_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Drive at a falling edge, then compare at the next falling edge.
  task automatic cyc(input bit clr, input bit v, input logic [LANES-1:0] act,
                     input logic [LANES*IDX_W-1:0] idx, input string tag);
    logic [LANES-1:0] ew = '0, eo = '0;
    bit erv;
    clr_i = clr; req_valid_i = v; lane_act_i = act; node_idx_i = idx;
    erv = v && !clr;
    if (clr) begin
      foreach (vis[n]) vis[n] = 1'b0;
    end else if (v) begin
      for (int k = 0; k < LANES; k++) begin
        if (act[k]) begin
          int n = int'(idx[k*IDX_W +: IDX_W]);
          eo[k] = vis[n];
          ew[k] = !vis[n];
          vis[n] = 1'b1;
        end
      end
    end
    @(negedge clk);
    checks++;
    if (rsp_valid_o !== erv || win_o !== ew || old_o !== eo) begin
      errors++;
      $display("FAIL %s: actual rsp=%b win=%b old=%b expected rsp=%b win=%b old=%b",
               tag, rsp_valid_o, win_o, old_o, erv, ew, eo);
    end
  endtask

  function automatic logic [LANES*IDX_W-1:0] pk(input int a0, a1, a2, a3, a4, a5, a6, a7);
    logic [LANES*IDX_W-1:0] r;
    r = {a7[IDX_W-1:0], a6[IDX_W-1:0], a5[IDX_W-1:0], a4[IDX_W-1:0],
         a3[IDX_W-1:0], a2[IDX_W-1:0], a1[IDX_W-1:0], a0[IDX_W-1:0]};
    return r;
  endfunction

  initial begin
    foreach (vis[n]) vis[n] = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid_o !== 1'b0 || win_o !== '0 || old_o !== '0) begin
      errors++;
      $display("FAIL R1: actual rsp=%b win=%b old=%b expected all zero", rsp_valid_o, win_o, old_o);
    end
    rst_n = 1'b1;
    cyc(0, 0, '0, '0, "R9");
    cyc(0, 1, 8'hFF, pk(0, 1, 2, 3, 4, 5, 6, 255), "R1");
    cyc(0, 1, 8'hFF, pk(0, 1, 2, 3, 4, 5, 6, 255), "R4");
    cyc(0, 1, 8'hFF, pk(10, 11, 12, 13, 14, 15, 16, 17), "R3");
    cyc(0, 1, 8'hFF, pk(100, 100, 100, 100, 100, 100, 100, 100), "R5");
    cyc(0, 1, 8'hFE, pk(101, 101, 101, 101, 101, 101, 101, 101), "R5");
    cyc(0, 1, 8'hA5, pk(102, 103, 102, 103, 103, 102, 103, 102), "R5");
    cyc(0, 0, 8'hFF, pk(120, 121, 122, 123, 124, 125, 126, 127), "R9");
    cyc(0, 1, 8'h01, pk(50, 51, 52, 53, 54, 55, 56, 57), "R6");
    cyc(0, 1, 8'hFE, pk(60, 51, 52, 53, 54, 55, 56, 57), "R6");
    cyc(0, 1, 8'hFF, pk(120, 61, 62, 63, 64, 65, 66, 67), "R6");
    cyc(0, 1, 8'h01, pk(70, 0, 0, 0, 0, 0, 0, 0), "R7");
    cyc(0, 1, 8'h08, pk(0, 0, 0, 70, 0, 0, 0, 0), "R7");
    cyc(1, 1, 8'hFF, pk(200, 201, 202, 203, 204, 205, 206, 207), "R8");
    cyc(0, 1, 8'hFF, pk(0, 1, 200, 100, 70, 60, 50, 255), "R8");
    cyc(1, 0, '0, '0, "R8");
    cyc(0, 1, 8'hFF, pk(0, 1, 200, 100, 70, 60, 50, 255), "R8");
    cyc(0, 1, 8'hFF, pk(201, 202, 203, 204, 205, 206, 207, 1), "R2");
    for (int t = 0; t < 400; t++) begin
      logic [LANES*IDX_W-1:0] idx;
      logic [LANES-1:0] act;
      for (int k = 0; k < LANES; k++) begin
        lfsr = (lfsr << 1) ^ ((lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]) ? 1 : 0);
        idx[k*IDX_W +: IDX_W] = IDX_W'(32 + (lfsr & 15));
        act[k] = lfsr[9];
      end
      cyc((t % 57) == 56, lfsr[5] | lfsr[7], act, idx, "R5");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule